// File: doc/BRIEF.md
# Byte-Serial Packet Content Scanner

This block sits behind a packet parser and looks inside packet payloads for a fixed set of byte patterns. Payload words arrive 32 bits at a time. A data-enable qualifies each word, and three flags travel with it: one marks the first word of a frame, one marks the word where the IP payload begins, and one marks the last word of the frame. Every qualified word is stored with its flags in a circular packet buffer. A read pointer then walks that buffer and feeds one byte per clock to a bank of pattern matchers that all run in parallel.

Scanning starts as soon as the first word of a frame is in the buffer. The scan therefore trails the writer and does not wait for the whole frame. When the last byte of the frame-end word has been examined, the block decides what happens to the packet. It can forward the packet by pushing a packet pointer, discard it by pushing nothing, and raise an alert by pushing an alert pointer that carries the per-expression match bits. Each expression is marked in a fixed table as a drop expression, an alert expression, or both. The downstream pointer queue can apply backpressure through a full input.

Top module: `contentScanner`

## Requirements
- R1: A word is written to the 512-entry buffer only in a cycle where `inValid` is high. Each written word takes the next buffer index, and the index wraps from 511 to 0. Word, data and flags are ignored while `inValid` is low.
- R2: Scanning runs concurrently with arrival. If all earlier words of a frame have already been scanned, a pointer for the frame appears no more than 8 clocks after its frame-end word is presented.
- R3: Bytes are scanned one per clock, most significant byte (bits 31:24) first. A pattern whose bytes are split across two adjacent words is found.
- R4: Words that come before the payload-start word are not scanned. Scanning begins at bits 31:24 of the word that carries the payload-start flag.
- R5: A frame start clears all match state. A pattern whose bytes are split between two frames is not found.
- R6: Match bit 0 is the text `ViRuS`, where its third and fifth characters accept either case and its other characters are exact. Match bit 1 is the exact bytes 0x6C 0x74 0x4E 0x50 0x76. Match bit 2 is the exact text `drop`.
- R7: When no drop expression matched, a packet pointer is pushed. It has `ptrAlert` = 0, `ptrAddr` equal to the buffer index of the frame-start word, and `ptrMatch` equal to the frame's match bits.
- R8: Bits 1 and 2 are drop expressions. If either one matched, no packet pointer is pushed for the frame.
- R9: Bits 0 and 2 are alert expressions. If either one matched, an alert pointer is pushed with `ptrAlert` = 1, the same `ptrAddr`, and the match bits. When a packet pointer is also pushed, the alert pointer follows it.
- R10: `ptrValid` is never high while `ptrFull` is high. While the queue is full, the pending pointer waits and scanning of the next frame is held.
- R11: The match bits are sticky within a frame. They report every expression that matched anywhere in the scanned payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Qualifies the input word and its flags |
| inWord | input | 32 | Payload word, first byte in bits 31:24 |
| inFrameStart | input | 1 | First word of a frame |
| inPayloadStart | input | 1 | Word where the scanned payload begins |
| inFrameEnd | input | 1 | Last word of a frame |
| ptrFull | input | 1 | Pointer queue cannot accept an entry |
| ptrValid | output | 1 | A pointer is pushed this cycle |
| ptrAlert | output | 1 | 1 = alert pointer, 0 = packet pointer |
| ptrAddr | output | 9 | Buffer index of the frame-start word |
| ptrMatch | output | 3 | Per-expression match bits of the frame |

## Verification
The hardest condition to reach is the scan trailing the writer in the middle of a frame. The read pointer has to catch up to the write pointer and sit idle, and the frame end must arrive afterwards. The bench reaches this by holding back the final word of a long frame for many cycles and then timing the pointer against it. The second condition is a pointer held under queue backpressure for a frame that is both forwarded and alerted. It is reached by raising the full input before the frame is sent and confirming that both expected pointers are still outstanding after a long wait.

// File: rtl/scanPkg.sv
`timescale 1ns/1ps
package scanPkg;
  localparam int WORD_W    = 32;
  localparam int FLAG_W    = 3;
  localparam int ENTRY_W   = WORD_W + FLAG_W;
  localparam int BUF_DEPTH = 512;
  localparam int ADDR_W    = $clog2(BUF_DEPTH);
  localparam int LANES     = WORD_W / 8;
  localparam int LANE_W    = $clog2(LANES);

  // flag positions inside the stored flag field
  localparam int FL_END   = 0;
  localparam int FL_PAY   = 1;
  localparam int FL_START = 2;

  // expression table: text right-aligned, first character most significant
  localparam int EXPR_N  = 3;
  localparam int MAX_LEN = 6;
  localparam logic [EXPR_N-1:0][MAX_LEN*8-1:0] PAT_TEXT =
    {{16'h0, "drop"}, {8'h0, 40'h6C744E5076}, {8'h0, "ViRuS"}};
  localparam logic [EXPR_N-1:0][MAX_LEN-1:0] PAT_FOLD =
    {6'b000000, 6'b000000, 6'b010100};
  localparam int PAT_LEN [EXPR_N] = '{5, 5, 4};
  localparam logic [EXPR_N-1:0] DROP_MASK  = 3'b110;
  localparam logic [EXPR_N-1:0] ALERT_MASK = 3'b101;

  typedef struct packed {
    logic              clear;    // new frame: reset matchers, latch start index
    logic              step;     // feed the selected byte to the matchers
    logic              advance;  // move the read pointer to the next entry
    logic [LANE_W-1:0] lane;     // byte lane, LANES-1 = bits 31:24
  } scanStrobe_t;
endpackage

// File: rtl/patMatcher.sv
`timescale 1ns/1ps
module patMatcher #(
  parameter int LEN = 5,
  parameter int MAX_LEN = 6,
  parameter logic [MAX_LEN*8-1:0] TEXT = '0,
  parameter logic [MAX_LEN-1:0]   FOLD = '0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clear,
  input  logic       step,
  input  logic [7:0] inByte,
  output logic       hit
);
  logic [LEN-2:0] active;  // active[i]: first i+1 characters end at the last byte
  logic [LEN-1:0] eq;
  logic [LEN-1:0] nextActive;

  for (genvar k = 0; k < LEN; k++) begin : g_pos
    localparam logic [7:0] CH = TEXT[(LEN-1-k)*8 +: 8];
    if (FOLD[k]) begin : g_fold
      assign eq[k] = (inByte | 8'h20) == (CH | 8'h20);
    end else begin : g_exact
      assign eq[k] = inByte == CH;
    end
  end

  assign nextActive = {active, 1'b1} & eq;

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      active <= '0;
      hit    <= 1'b0;
    end else if (step) begin
      active <= nextActive[LEN-2:0];
      if (nextActive[LEN-1]) hit <= 1'b1;
    end
  end

  // R11: a match stays reported until the next frame start
  a_r11_match_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !clear) |=> hit);
endmodule

// File: rtl/scanDatapath.sv
`timescale 1ns/1ps
module scanDatapath
  import scanPkg::*;
#(
  parameter int DEPTH = BUF_DEPTH,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord,
  input  logic [FLAG_W-1:0] inFlags,
  input  scanStrobe_t       strb,
  output logic              entryReady,
  output logic [FLAG_W-1:0] entryFlags,
  output logic [AW-1:0]     pktStart,
  output logic [EXPR_N-1:0] matchVec
);
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [AW-1:0]      wrPtr, rdPtr;
  logic [ENTRY_W-1:0] rdEntry;
  logic [7:0]         curByte;

  always_ff @(posedge clk) begin
    if (inValid) mem[wrPtr] <= {inFlags, inWord};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      pktStart <= '0;
    end else begin
      if (inValid)      wrPtr    <= wrPtr + 1'b1;
      if (strb.advance) rdPtr    <= rdPtr + 1'b1;
      if (strb.clear)   pktStart <= rdPtr;
    end
  end

  assign rdEntry    = mem[rdPtr];
  assign entryReady = rdPtr != wrPtr;
  assign entryFlags = rdEntry[ENTRY_W-1 -: FLAG_W];
  assign curByte    = rdEntry[{strb.lane, 3'b000} +: 8];

  for (genvar g = 0; g < EXPR_N; g++) begin : g_expr
    patMatcher #(
      .LEN(PAT_LEN[g]), .MAX_LEN(MAX_LEN),
      .TEXT(PAT_TEXT[g]), .FOLD(PAT_FOLD[g])
    ) u_match (
      .clk(clk), .rstN(rstN), .clear(strb.clear), .step(strb.step),
      .inByte(curByte), .hit(matchVec[g])
    );
  end

  // R1: buffer write index moves only with a qualified word
  a_r1_idle_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(wrPtr));
  // R5: frame start leaves no match bits standing
  a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (matchVec == '0));
endmodule

// File: rtl/scanCtrl.sv
`timescale 1ns/1ps
module scanCtrl
  import scanPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              entryReady,
  input  logic [FLAG_W-1:0] entryFlags,
  input  logic [EXPR_N-1:0] matchVec,
  input  logic              ptrFull,
  output scanStrobe_t       strb,
  output logic              ptrValid,
  output logic              ptrAlert
);
  typedef enum logic [2:0] {S_IDLE, S_HDR, S_SCAN, S_PKT, S_ALERT} scanState_t;
  scanState_t state, nextState;
  logic [LANE_W-1:0] lane;
  logic anyDrop, anyAlert;

  assign anyDrop  = |(matchVec & DROP_MASK);
  assign anyAlert = |(matchVec & ALERT_MASK);

  always_comb begin
    strb      = '0;
    ptrValid  = 1'b0;
    ptrAlert  = 1'b0;
    nextState = state;
    case (state)
      S_IDLE: if (entryReady) begin
        if (entryFlags[FL_START]) begin
          strb.clear = 1'b1;
          if (entryFlags[FL_PAY]) nextState = S_SCAN;
          else begin
            strb.advance = 1'b1;
            nextState = entryFlags[FL_END] ? S_PKT : S_HDR;
          end
        end else begin
          strb.advance = 1'b1;  // stray word outside a frame
        end
      end
      S_HDR: if (entryReady) begin
        if (entryFlags[FL_PAY]) nextState = S_SCAN;
        else begin
          strb.advance = 1'b1;
          if (entryFlags[FL_END]) nextState = S_PKT;
        end
      end
      S_SCAN: if (entryReady) begin
        strb.step = 1'b1;
        strb.lane = lane;
        if (lane == '0) begin
          strb.advance = 1'b1;
          if (entryFlags[FL_END]) nextState = S_PKT;
        end
      end
      S_PKT: begin
        if (anyDrop) nextState = anyAlert ? S_ALERT : S_IDLE;
        else if (!ptrFull) begin
          ptrValid  = 1'b1;
          nextState = anyAlert ? S_ALERT : S_IDLE;
        end
      end
      S_ALERT: if (!ptrFull) begin
        ptrValid  = 1'b1;
        ptrAlert  = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      lane  <= '1;
    end else begin
      state <= nextState;
      if (state == S_SCAN && entryReady) lane <= lane - 1'b1;
      else if (state != S_SCAN) lane <= '1;
    end
  end

  // R10: nothing is pushed into a full queue
  a_r10_no_push_when_full: assert property (@(posedge clk) disable iff (!rstN)
    ptrFull |-> !ptrValid);
  // R8: a packet pointer never leaves for a frame with a drop match
  a_r8_drop_blocks_packet: assert property (@(posedge clk) disable iff (!rstN)
    (ptrValid && !ptrAlert) |-> ((matchVec & DROP_MASK) == '0));
  // R9: an alert pointer always carries an alert match
  a_r9_alert_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    (ptrValid && ptrAlert) |-> ((matchVec & ALERT_MASK) != '0));
  // R10: a waiting pointer is not dropped while the queue is full
  a_r10_hold_pending: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ALERT && ptrFull) |=> (state == S_ALERT));
endmodule

// File: rtl/contentScanner.sv
`timescale 1ns/1ps
module contentScanner
  import scanPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord,
  input  logic              inFrameStart,
  input  logic              inPayloadStart,
  input  logic              inFrameEnd,
  input  logic              ptrFull,
  output logic              ptrValid,
  output logic              ptrAlert,
  output logic [ADDR_W-1:0] ptrAddr,
  output logic [EXPR_N-1:0] ptrMatch
);
  scanStrobe_t       strb;
  logic              entryReady;
  logic [FLAG_W-1:0] entryFlags;
  logic [FLAG_W-1:0] inFlags;

  always_comb begin
    inFlags           = '0;
    inFlags[FL_START] = inFrameStart;
    inFlags[FL_PAY]   = inPayloadStart;
    inFlags[FL_END]   = inFrameEnd;
  end

  scanDatapath #(.DEPTH(BUF_DEPTH)) u_datapath (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .inFlags(inFlags), .strb(strb), .entryReady(entryReady),
    .entryFlags(entryFlags), .pktStart(ptrAddr), .matchVec(ptrMatch)
  );

  scanCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .entryReady(entryReady), .entryFlags(entryFlags),
    .matchVec(ptrMatch), .ptrFull(ptrFull), .strb(strb),
    .ptrValid(ptrValid), .ptrAlert(ptrAlert)
  );
endmodule

// File: tb/contentScanner_bench.sv
`timescale 1ns/1ps
module contentScanner_bench;
  typedef logic [7:0] byteQ_t[$];

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic        inFrameStart = 1'b0, inPayloadStart = 1'b0, inFrameEnd = 1'b0;
  logic        ptrFull = 1'b0;
  logic        ptrValid, ptrAlert;
  logic [8:0]  ptrAddr;
  logic [2:0]  ptrMatch;

  contentScanner u_contentScanner (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .inFrameStart(inFrameStart), .inPayloadStart(inPayloadStart),
    .inFrameEnd(inFrameEnd), .ptrFull(ptrFull), .ptrValid(ptrValid),
    .ptrAlert(ptrAlert), .ptrAddr(ptrAddr), .ptrMatch(ptrMatch)
  );

  int checks = 0;
  int errors = 0;
  int wordCount = 0;
  bit         expAlert[$];
  int         expAddr[$];
  logic [2:0] expMatch[$];
  string patStr [3] = '{"ViRuS", "ltNPv", "drop"};

  function automatic bit foldAt(int e, int k);
    return (e == 0) && (k == 2 || k == 4);
  endfunction

  function automatic bit findPat(byteQ_t s, int e);
    int n = patStr[e].len();
    for (int i = 0; i + n <= s.size(); i++) begin
      bit ok = 1'b1;
      for (int k = 0; k < n; k++) begin
        logic [7:0] a = s[i+k];
        logic [7:0] p = patStr[e][k];
        if (foldAt(e, k)) ok &= ((a | 8'h20) == (p | 8'h20));
        else ok &= (a == p);
      end
      if (ok) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic byteQ_t s2q(string s);
    byteQ_t q;
    for (int i = 0; i < s.len(); i++) q.push_back(s[i]);
    return q;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model of the pointer stream, compared every clock
  always @(negedge clk) begin
    if (rstN) begin
      if (ptrFull && ptrValid) check(1'b0, "R10 push while full", 1, 0);
      if (ptrValid) begin
        if (expAlert.size() == 0) check(1'b0, "R8 unexpected pointer", int'(ptrAlert), -1);
        else begin
          check(ptrAlert == expAlert[0], "R7 R9 pointer type", int'(ptrAlert), int'(expAlert[0]));
          check(int'(ptrAddr) == expAddr[0], "R7 pointer address", int'(ptrAddr), expAddr[0]);
          check(ptrMatch == expMatch[0], "R11 R6 match bits", int'(ptrMatch), int'(expMatch[0]));
          void'(expAlert.pop_front()); void'(expAddr.pop_front()); void'(expMatch.pop_front());
        end
      end
    end
  end

  task automatic sendPkt(input byteQ_t hdr, input byteQ_t pay, input int endGap, input bit measure);
    logic [31:0] words[$];
    logic [31:0] cur = '0;
    int nh = (hdr.size() + 3) / 4;
    int np = (pay.size() + 3) / 4;
    logic [2:0] m;
    for (int i = 0; i < nh*4; i++) begin
      cur = {cur[23:0], (i < hdr.size()) ? hdr[i] : 8'h00};
      if (i % 4 == 3) words.push_back(cur);
    end
    for (int i = 0; i < np*4; i++) begin
      cur = {cur[23:0], (i < pay.size()) ? pay[i] : 8'h00};
      if (i % 4 == 3) words.push_back(cur);
    end
    for (int e = 0; e < 3; e++) m[e] = findPat(pay, e);
    if ((m & 3'b110) == 0) begin
      expAlert.push_back(1'b0); expAddr.push_back(wordCount % 512); expMatch.push_back(m);
    end
    if ((m & 3'b101) != 0) begin
      expAlert.push_back(1'b1); expAddr.push_back(wordCount % 512); expMatch.push_back(m);
    end
    for (int i = 0; i < words.size(); i++) begin
      if (i == words.size() - 1 && endGap > 0) begin
        inValid = 1'b0; inFrameStart = 1'b0; inPayloadStart = 1'b0; inFrameEnd = 1'b0;
        repeat (endGap) @(posedge clk);
        #1;
      end
      inValid = 1'b1;
      inWord = words[i];
      inFrameStart = (i == 0);
      inPayloadStart = (i == nh);
      inFrameEnd = (i == words.size() - 1);
      @(posedge clk); #1;
    end
    inValid = 1'b0; inFrameStart = 1'b0; inPayloadStart = 1'b0; inFrameEnd = 1'b0;
    wordCount += words.size();
    if (measure) begin
      int n = 0;
      while (!ptrValid && n < 40) begin @(negedge clk); n++; end
      check(n <= 8, "R2 pointer latency after frame end", n, 8);
      @(posedge clk); #1;
    end
    repeat (4*words.size() + 16) @(posedge clk);
    #1;
  endtask

  initial begin
    int n0;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(ptrValid == 1'b0, "R7 reset state no pointer", int'(ptrValid), 0);
    @(posedge clk); #1;

    // R7 plain frame, no match
    sendPkt(s2q("HDR1"), s2q("hello world"), 0, 1'b0);
    // R6 R9 exact text: forwarded and alerted
    sendPkt(s2q("HDR2"), s2q("xyViRuS!"), 0, 1'b0);
    // R6 case-fold positions accept either case
    sendPkt(s2q("HDR3"), s2q("a Virus b"), 0, 1'b0);
    // R6 positions without folding are exact
    sendPkt(s2q("HDR4"), s2q("vIRUS viRuS"), 0, 1'b0);
    // R8 drop-and-alert expression
    sendPkt(s2q("HDR5"), s2q("please drop me"), 0, 1'b0);
    // R8 drop-only expression: nothing queued
    sendPkt(s2q("HDR6"), s2q("zzltNPvzz"), 0, 1'b0);
    check(expAlert.size() == 0, "R8 dropped frame left no pointer", expAlert.size(), 0);
    // R3 pattern crossing a word boundary (V at bits 7:0 of first word)
    sendPkt(s2q("HDR7"), s2q("abcViRuSqq"), 0, 1'b0);
    // R4 pattern only in header words is not scanned
    sendPkt(s2q("dropdropViRuS"), s2q("clean data"), 0, 1'b0);
    // R5 pattern split across two frames
    sendPkt(s2q("HDR8"), s2q("endsVi"), 0, 1'b0);
    sendPkt(s2q("HDR9"), s2q("RuSnext"), 0, 1'b0);
    // R11 several expressions in one frame
    sendPkt(s2q("HDRA"), s2q("ViRuS and more ltNPv"), 0, 1'b0);
    sendPkt(s2q(""), s2q("drop... then ViRuS"), 0, 1'b0);
    // R1 words presented with enable low are not stored
    for (int i = 0; i < 10; i++) begin
      inWord = "drop"; inFrameStart = 1'b1; inPayloadStart = 1'b1; inFrameEnd = 1'b1;
      @(posedge clk); #1;
    end
    inFrameStart = 1'b0; inPayloadStart = 1'b0; inFrameEnd = 1'b0;
    sendPkt(s2q("HDRB"), s2q("after idle"), 0, 1'b0);
    // R2 scan trails the writer; final word held back
    sendPkt(s2q("HDRC"), s2q("the quick brown fox jumps over a lazy dog"), 60, 1'b1);
    // R10 backpressure on a forwarded and alerted frame
    ptrFull = 1'b1;
    sendPkt(s2q("HDRD"), s2q("xxVirusxx"), 0, 1'b0);
    repeat (40) @(posedge clk);
    #1;
    n0 = expAlert.size();
    check(n0 == 2, "R10 pointers held while full", n0, 2);
    ptrFull = 1'b0;
    repeat (20) @(posedge clk);
    #1;
    check(expAlert.size() == 0, "R9 R10 all pointers delivered", expAlert.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule